// File: doc/BRIEF.md
# Byte-Wide Register-Mapped SPI Master

This peripheral moves one byte at a time over a four-wire SPI link. It has no queue. Software programs a small bank of byte registers: a mode byte, a clock divisor and a transmit byte. It then writes a start command. The block runs eight serial clock cycles. In each one it drives a bit on the data-out line and samples the data-in line.

When the eighth bit has been sampled, the received byte is latched. A receive-ready flag rises and the interrupt line follows that flag. Software reads the received byte, which clears the flag, and then issues the next start. Every byte therefore costs exactly one interrupt.

The mode byte sets the serial clock idle level, the latching edge, the bit order, an internal loopback path and a port enable. The serial clock runs at the bus clock divided by four times (divisor + 1).

Top module: `spi_byte_master`

## Requirements
- R1: After an active-low reset, every register reads zero, and the serial clock, data-out and interrupt outputs are low.
- R2: The registers sit at these byte offsets: mode at 0 (bits 4:0 kept), received byte at 1 (read-only), transmit byte at 2, divisor at 6. Offsets 3 (start command, write-only) and 5 read as zero. A read returns data one clock after the read strobe.
- R3: Writing a value with bit 0 set to offset 3 starts a transfer, but only while the port is enabled (mode bit 0x08) and not busy. Each serial clock half-period lasts 2×(divisor+1) bus clocks, and a byte takes 16 half-periods.
- R4: Mode bit 0x02 sets the serial clock idle level (1 = high). Each half-period boundary toggles the clock.
- R5: Mode bit 0x10 selects the latching edge. When it is 1, the first bit is driven at start, data-in is sampled on each leading edge and data-out changes on each trailing edge. When it is 0, data-out changes on each leading edge after the first and data-in is sampled on each trailing edge.
- R6: Mode bit 0x04 shifts least-significant bit first. When clear, the most-significant bit goes first. This applies in both directions.
- R7: Mode bit 0x01 routes the outgoing bit stream back as received data and ignores the data-in pin.
- R8: At the end of the 16th half-period, the received byte is latched and the ready flag (status bit 0x01) and interrupt rise. Busy (status bit 0x02) is high from the cycle after the start until one bus clock after that end.
- R9: Reading offset 1 clears the ready flag and drops the interrupt.
- R10: A start command while busy, including the one extra busy cycle, is ignored. So is a transmit-byte write during a transfer: the byte being shifted is not disturbed.
- R11: With the port disabled, a start command is ignored. The serial clock stays at its idle level, data-out stays low and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low reset |
| addr | input | 3 | Register byte offset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid one clock after rdEn |
| irq | output | 1 | Interrupt, equal to the ready flag |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Suppose the half-period counter or the divider reload is off by one. The serial clock edges then drift from the expected cycle within one half-period, and the per-clock comparison of sclk and mosi catches this in the same cycle. A wrong shift or sample strobe shows up as a mismatched mosi bit at the next edge, or as a wrong received byte at the read that follows completion. A busy tail that is missing or too long changes the status read taken one and three cycles after completion. It also makes a start issued in the tail cycle either launch a visible clock or not.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_RXD  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_TXD  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_CMD  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_DIV  = 3'd6;

  // Field order follows the bit positions of the mode register (bit 4 down to bit 0)
  typedef struct packed {
    logic edgeLead;
    logic enable;
    logic lsbFirst;
    logic cpol;
    logic loopBack;
  } modeCfg_t;

  typedef struct packed {
    logic active;
    logic load;
    logic shiftTx;
    logic sample;
    logic done;
  } xferStrobe_t;
endpackage

// File: rtl/spi_byte_ctrl.sv
module spi_byte_ctrl
  import spi_byte_pkg::*;
#(
  parameter int BITS    = DATA_W,
  parameter int DIV_BITS = DIV_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startWr,
  input  modeCfg_t            cfg,
  input  logic [DIV_BITS-1:0] divisor,
  output xferStrobe_t         strobe,
  output logic                busy,
  output logic                sclk
);
  localparam int HALVES = 2 * BITS;
  localparam int HC_W   = $clog2(HALVES);
  localparam int CNT_W  = DIV_BITS + 1;

  logic             active;
  logic             tail;
  logic [HC_W-1:0]  halfCnt;
  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] reload;
  logic             tick;
  logic             halfLast;
  logic             accept;
  logic             oddHalf;

  assign reload   = {divisor, 1'b1};
  assign halfLast = (halfCnt == HC_W'(HALVES - 1));
  assign tick     = active && (divCnt == '0);
  assign busy     = active || tail;
  assign accept   = startWr && cfg.enable && !busy;
  assign oddHalf  = halfCnt[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      tail    <= 1'b0;
      halfCnt <= '0;
      divCnt  <= '0;
    end else begin
      tail <= 1'b0;
      if (accept) begin
        active  <= 1'b1;
        halfCnt <= '0;
        divCnt  <= reload;
      end else if (active) begin
        if (divCnt == '0) begin
          divCnt <= reload;
          if (halfLast) begin
            active  <= 1'b0;
            tail    <= 1'b1;
            halfCnt <= '0;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end else begin
          divCnt <= divCnt - 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.active = active;
    strobe.load   = accept;
    strobe.done   = tick && halfLast;
    if (cfg.edgeLead) begin
      strobe.sample  = tick && !oddHalf;
      strobe.shiftTx = tick && oddHalf && !halfLast;
    end else begin
      strobe.sample  = tick && oddHalf;
      strobe.shiftTx = tick && !oddHalf && (halfCnt != '0);
    end
  end

  assign sclk = active ? (cfg.cpol ^ oddHalf) : cfg.cpol;

  AST_TAIL_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    tail |=> !tail); // R8
  AST_DONE_TO_TAIL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.done |=> (tail && !active)); // R8
  AST_TAIL_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    tail |=> !active); // R10
  AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !cfg.enable) |=> !active); // R11
  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (active && $stable(divisor)) |-> (divCnt <= reload)); // R3
endmodule

// File: rtl/spi_byte_dp.sv
module spi_byte_dp
  import spi_byte_pkg::*;
#(
  parameter int BITS     = DATA_W,
  parameter int DIV_BITS = DIV_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [BITS-1:0]     wrData,
  output logic [BITS-1:0]     rdData,
  input  xferStrobe_t         strobe,
  input  logic                busy,
  output modeCfg_t            cfg,
  output logic [DIV_BITS-1:0] divisor,
  output logic                startWr,
  output logic                irq,
  output logic                mosi,
  input  logic                miso
);
  localparam int MODE_W = $bits(modeCfg_t);

  logic [BITS-1:0] txReg;
  logic [BITS-1:0] rxReg;
  logic [BITS-1:0] txSh;
  logic [BITS-1:0] rxSh;
  logic [BITS-1:0] rxShifted;
  logic [BITS-1:0] rxFinal;
  logic            ready;
  logic            txBit;
  logic            inBit;
  logic            rxRead;

  assign startWr = wrEn && (addr == OFS_CMD) && wrData[0];
  assign rxRead  = rdEn && (addr == OFS_RXD);
  assign txBit   = cfg.lsbFirst ? txSh[0] : txSh[BITS-1];
  assign mosi    = strobe.active && txBit;
  assign inBit   = cfg.loopBack ? mosi : miso;
  assign irq     = ready;

  always_comb begin
    if (cfg.lsbFirst) rxShifted = {inBit, rxSh[BITS-1:1]};
    else              rxShifted = {rxSh[BITS-2:0], inBit};
    rxFinal = strobe.sample ? rxShifted : rxSh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg     <= '0;
      txReg   <= '0;
      divisor <= '0;
    end else if (wrEn) begin
      case (addr)
        OFS_MODE: cfg     <= modeCfg_t'(wrData[MODE_W-1:0]);
        OFS_TXD:  txReg   <= wrData;
        OFS_DIV:  divisor <= wrData[DIV_BITS-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh <= '0;
      rxSh <= '0;
    end else if (strobe.load) begin
      txSh <= txReg;
      rxSh <= '0;
    end else begin
      if (strobe.shiftTx) txSh <= cfg.lsbFirst ? (txSh >> 1) : (txSh << 1);
      if (strobe.sample)  rxSh <= rxShifted;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg <= '0;
      ready <= 1'b0;
    end else if (strobe.done) begin
      rxReg <= rxFinal;
      ready <= 1'b1;
    end else if (rxRead) begin
      ready <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (rdEn) begin
      case (addr)
        OFS_MODE: rdData <= BITS'(cfg);
        OFS_RXD:  rdData <= rxReg;
        OFS_TXD:  rdData <= txReg;
        OFS_STAT: rdData <= BITS'({busy, ready});
        OFS_DIV:  rdData <= BITS'(divisor);
        default:  rdData <= '0;
      endcase
    end
  end

  AST_READY_FROM_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !ready ##1 ready |-> $past(strobe.done)); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rxRead && !strobe.done) |=> !ready); // R9
  AST_TX_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strobe.load && !strobe.shiftTx) |=> $stable(txSh)); // R10
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.active |-> !mosi); // R11
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_byte_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  xferStrobe_t       strobe;
  modeCfg_t          cfg;
  logic [DIV_W-1:0]  divisor;
  logic              startWr;
  logic              busy;

  spi_byte_ctrl #(.BITS(DATA_W), .DIV_BITS(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startWr(startWr), .cfg(cfg), .divisor(divisor),
    .strobe(strobe), .busy(busy), .sclk(sclk)
  );

  spi_byte_dp #(.BITS(DATA_W), .DIV_BITS(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .strobe(strobe), .busy(busy),
    .cfg(cfg), .divisor(divisor), .startWr(startWr), .irq(irq),
    .mosi(mosi), .miso(miso)
  );
endmodule

// File: tb/test_spi_byte_master.sv
module test_spi_byte_master;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] addr = '0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       irq, sclk, mosi;
  logic       miso = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycleNo = 0;
  bit monOn = 0;

  // behavioural reference state
  bit       xferOn = 0;
  bit       everStarted = 0;
  int       startNeg = 0;
  int       halfLen = 2;
  bit [7:0] curMode = 0;
  bit [7:0] curTx = 0;
  bit [7:0] curDiv = 0;
  bit [7:0] xMode = 0;
  bit [7:0] xTx = 0;
  bit [7:0] slaveByte = 0;
  bit       mReady = 0;

  always #5 clk = ~clk;

  spi_byte_master i_spi_byte_master (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .irq(irq), .sclk(sclk),
    .mosi(mosi), .miso(miso)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cycleNo);
    end
  endtask

  // per-clock reference comparison of the serial pins and interrupt
  always @(negedge clk) begin
    int t, half, bitIdx;
    bit eSclk, eMosi;
    cycleNo++;
    if (monOn) begin
      t = cycleNo - startNeg;
      if (xferOn && t == 16 * halfLen) begin
        xferOn = 0;
        mReady = 1;
      end
      if (xferOn) begin
        half = t / halfLen;
        if (xMode[4]) bitIdx = half / 2;
        else          bitIdx = (half == 0) ? 0 : (half - 1) / 2;
        if (xMode[2]) begin
          eMosi = xTx[bitIdx];
          miso  = slaveByte[bitIdx];
        end else begin
          eMosi = xTx[7 - bitIdx];
          miso  = slaveByte[7 - bitIdx];
        end
        eSclk = xMode[1] ^ half[0];
      end else begin
        eMosi = 1'b0;
        eSclk = curMode[1];
        miso  = 1'b0;
      end
      check("R3/R4/R5/R6/R8/R11 pins {sclk,mosi,irq}",
            int'({sclk, mosi, irq}), int'({eSclk, eMosi, mReady}));
    end
  end

  task automatic waitTo(int n);
    while (cycleNo < n - 1) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic regWrite(bit [2:0] a, bit [7:0] d);
    int n;
    @(negedge clk);
    #1;
    n = cycleNo;
    addr = a; wrData = d; wrEn = 1'b1;
    case (a)
      3'd0: curMode = {3'b000, d[4:0]};
      3'd2: curTx = d;
      3'd6: curDiv = d;
      3'd3: if (d[0] && curMode[3] &&
                !(everStarted && (n - startNeg) <= 16 * halfLen)) begin
              everStarted = 1;
              xferOn = 1;
              startNeg = n + 1;
              xMode = curMode;
              xTx = curTx;
              halfLen = 2 * (int'(curDiv) + 1);
            end
      default: ;
    endcase
    @(posedge clk);
    #1;
    wrEn = 1'b0;
  endtask

  task automatic regRead(bit [2:0] a, bit [7:0] exp, string tag);
    @(negedge clk);
    #1;
    addr = a; rdEn = 1'b1;
    @(posedge clk);
    #1;
    rdEn = 1'b0;
    if (a == 3'd1) mReady = 0;
    @(negedge clk);
    #1;
    check(tag, int'(rdData), int'(exp));
  endtask

  task automatic waitIdle();
    while (xferOn) begin
      @(negedge clk);
      #1;
    end
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic runByte(bit [7:0] mode, bit [7:0] dv, bit [7:0] tx, bit [7:0] slv,
                         bit [7:0] expRx, string tag);
    regWrite(3'd0, mode);
    regWrite(3'd6, dv);
    regWrite(3'd2, tx);
    slaveByte = slv;
    regWrite(3'd3, 8'h01);
    waitIdle();
    check({tag, " irq after byte R8"}, int'(irq), 1);
    regRead(3'd1, expRx, {tag, " received byte"});
    check({tag, " irq cleared by rx read R9"}, int'(irq), 0);
  endtask

  initial begin
    #(200_000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 sclk in reset", int'(sclk), 0);
    check("R1 mosi in reset", int'(mosi), 0);
    check("R1 irq in reset", int'(irq), 0);
    check("R1 rdData in reset", int'(rdData), 0);
    #1 rstN = 1'b1;
    monOn = 1;
    regRead(3'd0, 8'h00, "R1 mode after reset");
    regRead(3'd6, 8'h00, "R1 divisor after reset");
    regRead(3'd4, 8'h00, "R1 status after reset");

    // R2 register map
    regWrite(3'd0, 8'hF8);
    regRead(3'd0, 8'h18, "R2 mode keeps bits 4:0");
    regWrite(3'd2, 8'hA5);
    regRead(3'd2, 8'hA5, "R2 transmit byte readback");
    regWrite(3'd6, 8'h7B);
    regRead(3'd6, 8'h7B, "R2 divisor readback");
    regRead(3'd3, 8'h00, "R2 command offset reads zero");
    regRead(3'd5, 8'h00, "R2 unused offset reads zero");

    // R3 R5 R8: leading-edge latch, MSB first, busy and ready timing
    regWrite(3'd6, 8'h00);
    slaveByte = 8'h3C;
    regWrite(3'd3, 8'h01);
    waitTo(startNeg + 16 * halfLen - 2);
    regRead(3'd4, 8'h02, "R8 busy before completion");
    regRead(3'd4, 8'h03, "R8 ready and busy tail");
    regRead(3'd4, 8'h01, "R8 busy dropped after one cycle");
    regRead(3'd1, 8'h3C, "R5 received byte leading edge");
    check("R9 irq cleared", int'(irq), 0);
    regRead(3'd4, 8'h00, "R9 ready cleared");

    // R4 R5 R10: idle-high clock, trailing latch, mid-transfer start and tx write
    regWrite(3'd0, 8'h0A);
    regWrite(3'd6, 8'h02);
    regWrite(3'd2, 8'h96);
    slaveByte = 8'hC3;
    regWrite(3'd3, 8'h01);
    waitTo(startNeg + 20);
    regWrite(3'd2, 8'h11);
    regWrite(3'd3, 8'h01);
    waitTo(startNeg + 16 * halfLen);
    regWrite(3'd3, 8'h01);
    repeat (4) @(negedge clk);
    #1;
    regRead(3'd4, 8'h01, "R10 start in busy tail ignored");
    regRead(3'd1, 8'hC3, "R4/R5 received byte trailing edge");

    // R6 both phases, LSB first
    runByte(8'h0C, 8'h01, 8'h1D, 8'hB2, 8'hB2, "R6 lsb trailing");
    runByte(8'h1E, 8'h00, 8'h81, 8'h47, 8'h47, "R6 lsb leading idle-high");

    // R7 loopback ignores miso
    runByte(8'h19, 8'h00, 8'h5E, 8'hFF, 8'h5E, "R7 loopback msb");
    runByte(8'h0D, 8'h01, 8'hC4, 8'h00, 8'hC4, "R7 loopback lsb trailing");

    // R11 disabled port ignores start
    regWrite(3'd0, 8'h12);
    regWrite(3'd2, 8'hFF);
    regWrite(3'd3, 8'h01);
    repeat (40) @(negedge clk);
    #1;
    regRead(3'd4, 8'h00, "R11 disabled not busy");
    check("R11 disabled no irq", int'(irq), 0);
    check("R11 disabled clock idle", int'(sclk), 1);
    check("R11 disabled mosi low", int'(mosi), 0);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule